// File: doc/BRIEF.md
# Pin Interrupt Controller Register Block

This block watches 32 external pins and raises one interrupt line when any enabled pin has an event pending. Each pin is brought into the clock domain through a two-flop synchronizer, can be inverted, and is then detected in one of two ways. In edge mode a rising transition is captured and held until software clears it. In level mode the pending bit follows the pin level. The pending bits, ANDed with an enable mask, drive the interrupt output.

Software reaches the block through a simple 32-bit register bus. The bus has a request strobe, a write enable, a byte offset, a full-word flag and combinational read data. The enable mask, the edge-mode selection and the invert selection have no direct address. Each one is changed through a pair of aliases: one alias sets bits and the other clears them. A read of either alias returns the shared word. An assign word is stored for routing logic elsewhere. Its reset value depends on an instance parameter.

Word map, by byte offset:

| Offset | Word |
|---|---|
| 0x00 | mask set alias |
| 0x04 | mask clear alias |
| 0x08 | request |
| 0x0C | assign |
| 0x10 | edge-mode set alias |
| 0x14 | edge-mode clear alias |
| 0x18 | invert set alias |
| 0x1C | invert clear alias |
| 0x20 | pin state |
| 0x24 | pending latch |

Top module: `pirq_ctrl`

## Requirements
- R1: The map holds ten 32-bit words at byte offsets 0x00 to 0x24, as listed in the table above. A read at each offset returns the word the table names there.
- R2: A write to a set alias forces to 1 each bit written as 1. A write to a clear alias forces to 0 each bit written as 1. Bits written as 0 keep their value.
- R3: A read of either alias of a pair returns the current shared word.
- R4: The assign word at 0x0C stores a written value and reads it back. Its reset value is selected by INST_ID: instances 0 and 2 reset to 0x00000101, instance 1 resets to 0x01010000, and instance 3 resets to 0x02020303.
- R5: An access is flagged on err_o, in the same cycle, when req_i is high and any of these holds: full_i is 0, addr_i[1:0] is not 0, or the word index addr_i[5:2] is above 9. A flagged access changes no state and reads as 0.
- R6: The pin-state word (0x20) reads each pin XOR its invert bit, after a two-flop synchronizer. A write to 0x20 has no effect.
- R7: In level mode (edge-mode bit 0), the latch bit equals the synchronized, inverted pin as sampled one cycle earlier.
- R8: In edge mode (edge-mode bit 1), a latch bit is set one cycle after a rising transition of the synchronized, inverted pin. The bit holds until a 1 is written to that bit position at 0x24 or 0x08. If a new rising transition arrives in the same cycle as the clear, the bit is set.
- R9: A read of the request word (0x08) returns the latch ANDed with the mask.
- R10: irq_o is high whenever any bit of the latch ANDed with the mask is 1.
- R11: After reset, the mask, edge-mode, invert and latch words are 0, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin inputs |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| full_i | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| err_o | output | 1 | Access error, combinational |
| irq_o | output | 1 | Interrupt output |

## Verification
Read data and err_o are combinational, so the bench samples them 1 ns after it drives an access on the falling edge. A write takes effect at the next rising edge and is checked on a read in a later cycle. A pin change reaches the pin-state word two rising edges after it is driven and reaches the latch and irq_o one edge after that. The bench keeps these delays with a reference model that steps on every rising edge. It compares irq_o on every falling edge and compares each read against the model's state. Directed cases are mixed with a fixed-seed random sequence of pin changes and accesses, some of them flagged as errors.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int DW        = 32;
  localparam int NUM_WORDS = 10;
  localparam int ADDR_W    = $clog2(NUM_WORDS * 4);
  localparam int IDX_W     = ADDR_W - 2;

  localparam logic [IDX_W-1:0] IX_MSK_SET = 4'd0;
  localparam logic [IDX_W-1:0] IX_MSK_CLR = 4'd1;
  localparam logic [IDX_W-1:0] IX_REQ     = 4'd2;
  localparam logic [IDX_W-1:0] IX_ASG     = 4'd3;
  localparam logic [IDX_W-1:0] IX_EDG_SET = 4'd4;
  localparam logic [IDX_W-1:0] IX_EDG_CLR = 4'd5;
  localparam logic [IDX_W-1:0] IX_INV_SET = 4'd6;
  localparam logic [IDX_W-1:0] IX_INV_CLR = 4'd7;
  localparam logic [IDX_W-1:0] IX_PSTATE  = 4'd8;
  localparam logic [IDX_W-1:0] IX_LATCH   = 4'd9;

  function automatic logic [DW-1:0] asg_reset(input int id);
    case (id)
      1:       return 32'h0101_0000;
      3:       return 32'h0202_0303;
      default: return 32'h0000_0101;
    endcase
  endfunction
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      warm_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
  end

  assign q_o = s2_q;

  AST_SYNC_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2) |-> (q_o == $past(d_i, 2))); // R6
endmodule

// File: rtl/pirq_detect.sv
module pirq_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] inv_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] latch_o
);
  logic [W-1:0] prev_q, latch_q;

  assign lvl_o = sync_i ^ inv_i;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise;
    assign rise = lvl_o[i] & ~prev_q[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[i]  <= 1'b0;
        latch_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= lvl_o[i];
        if (edge_i[i]) latch_q[i] <= (latch_q[i] & ~clr_i[i]) | rise;
        else           latch_q[i] <= lvl_o[i];
      end
    end
  end

  assign latch_o = latch_q;

  AST_LEVEL_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((latch_q & ~$past(edge_i)) == ($past(lvl_o) & ~$past(edge_i)))); // R7

  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(latch_q & edge_i & ~clr_i) & ~latch_q) == '0)); // R8
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
#(
  parameter int INST_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              full_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     pstate_i,
  input  logic [DW-1:0]     latch_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  output logic [DW-1:0]     mask_o,
  output logic [DW-1:0]     edge_o,
  output logic [DW-1:0]     inv_o,
  output logic [DW-1:0]     clr_o
);
  localparam logic [DW-1:0] ASG_RST = asg_reset(INST_ID);

  logic [DW-1:0]    mask_q, edge_q, inv_q, asg_q;
  logic [IDX_W-1:0] idx;
  logic             bad, wr_ok, rd_ok;

  assign idx   = addr_i[ADDR_W-1:2];
  assign bad   = !full_i || (addr_i[1:0] != 2'b00) || (int'(idx) >= NUM_WORDS);
  assign err_o = req_i && bad;
  assign wr_ok = req_i && we_i && !bad;
  assign rd_ok = req_i && !we_i && !bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      edge_q <= '0;
      inv_q  <= '0;
      asg_q  <= ASG_RST;
    end else if (wr_ok) begin
      case (idx)
        IX_MSK_SET: mask_q <= mask_q | wdata_i;
        IX_MSK_CLR: mask_q <= mask_q & ~wdata_i;
        IX_ASG:     asg_q  <= wdata_i;
        IX_EDG_SET: edge_q <= edge_q | wdata_i;
        IX_EDG_CLR: edge_q <= edge_q & ~wdata_i;
        IX_INV_SET: inv_q  <= inv_q | wdata_i;
        IX_INV_CLR: inv_q  <= inv_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  // request and latch addresses clear captured edges
  assign clr_o = (wr_ok && (idx == IX_REQ || idx == IX_LATCH)) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      case (idx)
        IX_MSK_SET, IX_MSK_CLR: rdata_o = mask_q;
        IX_REQ:                 rdata_o = latch_i & mask_q;
        IX_ASG:                 rdata_o = asg_q;
        IX_EDG_SET, IX_EDG_CLR: rdata_o = edge_q;
        IX_INV_SET, IX_INV_CLR: rdata_o = inv_q;
        IX_PSTATE:              rdata_o = pstate_i;
        IX_LATCH:               rdata_o = latch_i;
        default:                rdata_o = '0;
      endcase
    end
  end

  assign mask_o = mask_q;
  assign edge_o = edge_q;
  assign inv_o  = inv_q;

  AST_ERR_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> ($stable(mask_q) && $stable(edge_q) && $stable(inv_q) && $stable(asg_q))); // R5

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && idx == IX_MSK_SET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i))); // R2

  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && idx == IX_MSK_CLR) |=> ((mask_q & $past(wdata_i)) == '0)); // R2

  AST_SET_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && idx == IX_INV_SET) |=> ((inv_q & ~$past(wdata_i)) == ($past(inv_q) & ~$past(wdata_i)))); // R2
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int INST_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     pin_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              full_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  output logic              irq_o
);
  logic [DW-1:0] sync, lvl, latch, mask, edge_sel, inv, clr;

  pirq_sync #(.W(DW)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync)
  );

  pirq_detect #(.W(DW)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync), .inv_i(inv),
    .edge_i(edge_sel), .clr_i(clr), .lvl_o(lvl), .latch_o(latch)
  );

  pirq_regs #(.INST_ID(INST_ID)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .full_i(full_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .pstate_i(lvl), .latch_i(latch), .rdata_o(rdata_o), .err_o(err_o),
    .mask_o(mask), .edge_o(edge_sel), .inv_o(inv), .clr_o(clr)
  );

  assign irq_o = |(latch & mask);

  AST_IRQ_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !irq_o); // R11
endmodule

// File: tb/pirq_ctrl_tb.sv
module pirq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin = '0;
  logic        req = 1'b0, we = 1'b0, full = 1'b1;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err, irq;

  int checks = 0, fails = 0;
  bit done = 0, mon_on = 0;

  logic [31:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_mask = '0, m_edge = '0,
               m_inv = '0, m_latch = '0, m_asg = 32'h0000_0101;

  pirq_ctrl #(.INST_ID(0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .req_i(req), .we_i(we),
    .full_i(full), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .err_o(err), .irq_o(irq)
  );

  always #5 clk = ~clk;

  function automatic bit acc_bad(input logic f, input logic [5:0] a);
    return !f || a[1:0] != 2'b00 || a[5:2] > 4'd9;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] ix);
    case (ix)
      4'd0, 4'd1: return m_mask;
      4'd2:       return m_latch & m_mask;
      4'd3:       return m_asg;
      4'd4, 4'd5: return m_edge;
      4'd6, 4'd7: return m_inv;
      4'd8:       return m_s2 ^ m_inv;
      4'd9:       return m_latch;
      default:    return '0;
    endcase
  endfunction

  // reference model, steps on every rising edge
  always @(posedge clk) begin
    logic [31:0] lvl, rise, clr, nl;
    logic [3:0]  ix;
    bit          wok;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_mask = '0; m_edge = '0;
      m_inv = '0; m_latch = '0; m_asg = 32'h0000_0101;
    end else begin
      lvl = m_s2 ^ m_inv;
      rise = lvl & ~m_prev;
      ix = addr[5:2];
      wok = req && we && !acc_bad(full, addr);
      clr = (wok && (ix == 4'd2 || ix == 4'd9)) ? wdata : '0;
      nl = (m_edge & ((m_latch & ~clr) | rise)) | (~m_edge & lvl);
      if (wok) begin
        case (ix)
          4'd0: m_mask = m_mask | wdata;
          4'd1: m_mask = m_mask & ~wdata;
          4'd3: m_asg  = wdata;
          4'd4: m_edge = m_edge | wdata;
          4'd5: m_edge = m_edge & ~wdata;
          4'd6: m_inv  = m_inv | wdata;
          4'd7: m_inv  = m_inv & ~wdata;
          default: ;
        endcase
      end
      m_prev = lvl; m_s2 = m_s1; m_s1 = pin; m_latch = nl;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      #2;
      chk(irq == |(m_latch & m_mask), "R10 irq", {31'd0, irq}, {31'd0, |(m_latch & m_mask)});
    end
  end

  task automatic acc(input logic w, input logic [5:0] a, input logic [31:0] d,
                     input logic f, input string tag);
    logic [31:0] e;
    bit          b;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; full = f;
    #1;
    b = acc_bad(f, a);
    chk(err == b, {tag, " err"}, {31'd0, err}, {31'd0, b});
    if (!w) begin
      e = b ? 32'd0 : exp_rd(a[5:2]);
      chk(rdata == e, tag, rdata, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b0; we = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1;
    #1;
    chk(irq == 1'b0, "R11 irq after reset", {31'd0, irq}, 32'd0);
    // R11 R4 R1: every word after reset
    for (int k = 0; k < 10; k++) acc(1'b0, 6'(k * 4), '0, 1'b1, "R1 R11 R4 reset read");
    chk(m_asg == 32'h0000_0101, "R4 assign default", m_asg, 32'h0000_0101);
    // R2 / R3 aliases
    acc(1'b1, 6'h00, 32'h0000_00F0, 1'b1, "R2 mask set");
    acc(1'b1, 6'h04, 32'h0000_0030, 1'b1, "R2 mask clr");
    acc(1'b0, 6'h00, '0, 1'b1, "R3 read set alias");
    acc(1'b0, 6'h04, '0, 1'b1, "R3 read clr alias");
    acc(1'b1, 6'h0C, 32'hDEAD_BEEF, 1'b1, "R4 assign write");
    acc(1'b0, 6'h0C, '0, 1'b1, "R4 assign read");
    // R5 error cases
    acc(1'b1, 6'h00, 32'hFFFF_FFFF, 1'b0, "R5 half write");
    acc(1'b1, 6'h28, 32'hFFFF_FFFF, 1'b1, "R5 bad offset");
    acc(1'b1, 6'h01, 32'hFFFF_FFFF, 1'b1, "R5 misaligned");
    acc(1'b0, 6'h00, '0, 1'b1, "R5 mask untouched");
    acc(1'b0, 6'h2C, '0, 1'b1, "R5 bad read");
    // R8 edge capture and clear
    acc(1'b1, 6'h10, 32'h0000_0001, 1'b1, "R8 edge set");
    acc(1'b1, 6'h00, 32'h0000_00FF, 1'b1, "R2 mask set");
    idle(1); pin[0] = 1'b1; idle(4);
    acc(1'b0, 6'h24, '0, 1'b1, "R8 latch captured");
    chk(irq == 1'b1, "R10 irq asserted", {31'd0, irq}, 32'd1);
    idle(1); pin[0] = 1'b0; idle(4);
    acc(1'b0, 6'h24, '0, 1'b1, "R8 latch held");
    acc(1'b0, 6'h08, '0, 1'b1, "R9 request read");
    acc(1'b1, 6'h08, 32'h0000_0001, 1'b1, "R8 clear via request");
    acc(1'b0, 6'h24, '0, 1'b1, "R8 cleared");
    // R7 level mode
    idle(1); pin[4] = 1'b1; idle(4);
    acc(1'b0, 6'h24, '0, 1'b1, "R7 level high");
    idle(1); pin[4] = 1'b0; idle(4);
    acc(1'b0, 6'h24, '0, 1'b1, "R7 level low");
    // R6 invert and pin-state write ignored
    acc(1'b1, 6'h18, 32'h0000_0020, 1'b1, "R2 invert set");
    idle(3);
    acc(1'b0, 6'h20, '0, 1'b1, "R6 inverted pin state");
    acc(1'b1, 6'h20, 32'h0000_0000, 1'b1, "R6 pin state write");
    acc(1'b0, 6'h20, '0, 1'b1, "R6 pin state unchanged");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 3) begin
        @(negedge clk); req = 1'b0;
        pin = pin ^ (32'h1 << $urandom_range(0, 31));
      end else if (sel < 7) begin
        acc(1'b0, 6'($urandom_range(0, 11) * 4), '0, ($urandom_range(0, 15) != 0), "R1 R9 R6 random read");
      end else begin
        logic [5:0] a = 6'($urandom_range(0, 10) * 4);
        if ($urandom_range(0, 7) == 0) a = a | 6'd2;
        acc(1'b1, a, $urandom & $urandom, ($urandom_range(0, 15) != 0), "R2 R8 random write");
      end
    end
    idle(2);
    finish_run();
  end
endmodule